// File: doc/BRIEF.md
# UART Interrupt and Status Controller

This block is the register-side control logic of a simple serial port. It collects level status from the receiver, the transmitter and two DMA channels. It also holds three sticky receive-error flags. All of these are packed into one status word. A mask register, which can only be changed through separate write-one-to-set and write-one-to-clear addresses, chooses which status bits drive a single registered interrupt line.

The same register bus carries a write-only command word. The block turns that word into single-cycle pulses that reset, enable or disable the receiver and the transmitter, and that clear the error flags. The serial datapath and the DMA pointer and counter logic sit outside this block and consume these pulses.

Register map (word index on `bus_addr_i`): 0 command (write-only), 1 mask set (write-only), 2 mask clear (write-only), 3 mask (read-only), 4 status (read-only). Any other index reads as zero.

Top module: `uart_irq_ctl`

## Requirements
- R1: The status word places the following fields at these bits, and every other bit reads 0:
  - bit 0: receiver ready
  - bit 1: transmitter ready
  - bit 3: end of receive transfer
  - bit 4: end of transmit transfer
  - bit 5: overrun flag
  - bit 6: framing flag
  - bit 7: parity flag
  - bit 9: transmitter empty
  - bit 11: transmit buffer empty
  - bit 12: receive buffer full
- R2: A write to the mask-set address (1) sets each mask bit whose data bit is 1. Data bits that are 0 leave the mask unchanged. Only the ten bits listed in R1 can ever be set.
- R3: A write to the mask-clear address (2) clears each mask bit whose data bit is 1. Data bits that are 0 leave the mask unchanged.
- R4: The mask resets to all zeros. A write to the mask address (3) has no effect on it.
- R5: Each error flag (overrun bit 5, framing bit 6, parity bit 7) is set by its one-cycle event input. It stays set until a reset-status command arrives, whatever other commands are written in the meantime.
- R6: A command write with bit 8 set clears all three error flags. If an error event arrives in the same cycle, that flag ends up set.
- R7: Command bits have these meanings:
  - bit 2: receiver reset
  - bit 3: transmitter reset
  - bit 4: receiver enable
  - bit 5: receiver disable
  - bit 6: transmitter enable
  - bit 7: transmitter disable
  - bit 8: reset status

  Each bit written as 1 gives a pulse on its output for exactly the one cycle after the write. Bits written as 0 give no pulse.
- R8: An enable pulse is produced only when the matching disable bit is 0 in the same write, so disable wins.
- R9: The interrupt output is the OR over all bits of status AND mask. It is registered, and follows the status and mask one cycle later.
- R10: Read data is registered, and appears the cycle after the read strobe. Reads of the command, mask-set and mask-clear addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Word index |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| rx_rdy_i | input | 1 | Receiver holds an unread character |
| tx_rdy_i | input | 1 | Transmit holding register free |
| tx_empty_i | input | 1 | Transmitter fully idle |
| rx_end_i | input | 1 | Receive DMA end of transfer |
| tx_end_i | input | 1 | Transmit DMA end of transfer |
| tx_bufe_i | input | 1 | Transmit DMA buffer empty |
| rx_buff_i | input | 1 | Receive DMA buffer full |
| ovr_evt_i | input | 1 | Overrun event pulse |
| frm_evt_i | input | 1 | Framing error event pulse |
| par_evt_i | input | 1 | Parity error event pulse |
| rx_reset_o | output | 1 | Receiver reset pulse |
| tx_reset_o | output | 1 | Transmitter reset pulse |
| rx_enable_o | output | 1 | Receiver enable pulse |
| rx_disable_o | output | 1 | Receiver disable pulse |
| tx_enable_o | output | 1 | Transmitter enable pulse |
| tx_disable_o | output | 1 | Transmitter disable pulse |
| err_clear_o | output | 1 | Reset-status pulse |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is the race between an error event and a reset-status command that land on the same clock edge. The bench first sets one flag, then raises a different error event in the same half-cycle as the command write. It then checks that the old flag is gone and the new one remains. The interrupt's one-cycle lag is also exercised: the bench looks at the line both on the cycle right after a mask change and on the cycle after that.

// File: rtl/uic_pkg.sv
package uic_pkg;
  localparam int STAT_W = 13;
  localparam int CMD_W  = 9;
  localparam int N_ERR  = 3;
  localparam int N_CMD  = 7;

  localparam int B_RXRDY  = 0;
  localparam int B_TXRDY  = 1;
  localparam int B_RXEND  = 3;
  localparam int B_TXEND  = 4;
  localparam int B_ERR0   = 5;   // overrun, framing, parity follow in order
  localparam int B_TXEMPT = 9;
  localparam int B_TXBUFE = 11;
  localparam int B_RXBUFF = 12;

  localparam logic [STAT_W-1:0] STAT_VALID = 13'h1AFB;

  // command word bit positions
  localparam int C_RSTRX = 2;
  localparam int C_RSTTX = 3;
  localparam int C_RXON  = 4;
  localparam int C_RXOFF = 5;
  localparam int C_TXON  = 6;
  localparam int C_TXOFF = 7;
  localparam int C_CLRER = 8;

  // pulse vector indices
  typedef enum int {
    P_RSTRX = 0, P_RSTTX = 1, P_RXON = 2, P_RXOFF = 3,
    P_TXON  = 4, P_TXOFF = 5, P_CLRER = 6
  } pulse_idx_e;

  typedef enum logic [2:0] {
    A_CMD  = 3'd0,
    A_MSET = 3'd1,
    A_MCLR = 3'd2,
    A_MASK = 3'd3,
    A_STAT = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/uic_cmd_decode.sv
module uic_cmd_decode
  import uic_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wd,
  output logic [N_CMD-1:0] pulse_o
);
  logic [N_CMD-1:0] next_pulse;
  logic unused_cmd_lo;
  assign unused_cmd_lo = ^cmd_wd[1:0];

  always_comb begin
    next_pulse = '0;
    if (cmd_we) begin
      next_pulse[P_RSTRX] = cmd_wd[C_RSTRX];
      next_pulse[P_RSTTX] = cmd_wd[C_RSTTX];
      next_pulse[P_RXOFF] = cmd_wd[C_RXOFF];
      next_pulse[P_TXOFF] = cmd_wd[C_TXOFF];
      next_pulse[P_RXON]  = cmd_wd[C_RXON] & ~cmd_wd[C_RXOFF];
      next_pulse[P_TXON]  = cmd_wd[C_TXON] & ~cmd_wd[C_TXOFF];
      next_pulse[P_CLRER] = cmd_wd[C_CLRER];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_o <= '0;
    else     pulse_o <= next_pulse;
  end

  p_dis_wins_r8: assert property (@(posedge clk) disable iff (rst)
    !(pulse_o[P_RXON] && pulse_o[P_RXOFF]) && !(pulse_o[P_TXON] && pulse_o[P_TXOFF]));
  p_no_write_no_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    !cmd_we |=> (pulse_o == '0));
endmodule

// File: rtl/uic_mask_reg.sv
module uic_mask_reg
  import uic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] wd,
  output logic [STAT_W-1:0] mask_o
);
  logic [STAT_W-1:0] wd_valid;
  assign wd_valid = wd & STAT_VALID;

  always_ff @(posedge clk) begin
    if (rst)         mask_o <= '0;
    else if (set_we) mask_o <= mask_o | wd_valid;
    else if (clr_we) mask_o <= mask_o & ~wd_valid;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((mask_o & $past(wd_valid)) == $past(wd_valid)));
  p_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((mask_o & $past(wd_valid)) == '0));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(mask_o));
endmodule

// File: rtl/uic_status.sv
module uic_status
  import uic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_rdy,
  input  logic              tx_rdy,
  input  logic              tx_empty,
  input  logic              rx_end,
  input  logic              tx_end,
  input  logic              tx_bufe,
  input  logic              rx_buff,
  input  logic [N_ERR-1:0]  err_evt,
  input  logic              err_clr,
  output logic [STAT_W-1:0] status_o
);
  logic [N_ERR-1:0] err_q;

  for (genvar i = 0; i < N_ERR; i++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst)             err_q[i] <= 1'b0;
      else if (err_evt[i]) err_q[i] <= 1'b1;
      else if (err_clr)    err_q[i] <= 1'b0;
    end

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      (err_q[i] && !err_clr) |=> err_q[i]);
    p_evt_wins_r6: assert property (@(posedge clk) disable iff (rst)
      err_evt[i] |=> err_q[i]);
  end

  always_comb begin
    status_o = '0;
    status_o[B_RXRDY]  = rx_rdy;
    status_o[B_TXRDY]  = tx_rdy;
    status_o[B_RXEND]  = rx_end;
    status_o[B_TXEND]  = tx_end;
    status_o[B_TXEMPT] = tx_empty;
    status_o[B_TXBUFE] = tx_bufe;
    status_o[B_RXBUFF] = rx_buff;
    status_o[B_ERR0 +: N_ERR] = err_q;
  end
endmodule

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
  import uic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              rx_rdy_i,
  input  logic              tx_rdy_i,
  input  logic              tx_empty_i,
  input  logic              rx_end_i,
  input  logic              tx_end_i,
  input  logic              tx_bufe_i,
  input  logic              rx_buff_i,
  input  logic              ovr_evt_i,
  input  logic              frm_evt_i,
  input  logic              par_evt_i,
  output logic              rx_reset_o,
  output logic              tx_reset_o,
  output logic              rx_enable_o,
  output logic              rx_disable_o,
  output logic              tx_enable_o,
  output logic              tx_disable_o,
  output logic              err_clear_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic              we_cmd, we_set, we_clr;
  logic [STAT_W-1:0] mask_q, status_w;
  logic [N_CMD-1:0]  pulses;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata_i[DATA_W-1:STAT_W];

  assign we_cmd = bus_wr_i && (bus_addr_i == ADDR_W'(A_CMD));
  assign we_set = bus_wr_i && (bus_addr_i == ADDR_W'(A_MSET));
  assign we_clr = bus_wr_i && (bus_addr_i == ADDR_W'(A_MCLR));

  uic_cmd_decode u_cmd (
    .clk     (clk),
    .rst     (rst),
    .cmd_we  (we_cmd),
    .cmd_wd  (bus_wdata_i[CMD_W-1:0]),
    .pulse_o (pulses)
  );

  uic_mask_reg u_mask (
    .clk    (clk),
    .rst    (rst),
    .set_we (we_set),
    .clr_we (we_clr),
    .wd     (bus_wdata_i[STAT_W-1:0]),
    .mask_o (mask_q)
  );

  uic_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .rx_rdy   (rx_rdy_i),
    .tx_rdy   (tx_rdy_i),
    .tx_empty (tx_empty_i),
    .rx_end   (rx_end_i),
    .tx_end   (tx_end_i),
    .tx_bufe  (tx_bufe_i),
    .rx_buff  (rx_buff_i),
    .err_evt  ({par_evt_i, frm_evt_i, ovr_evt_i}),
    .err_clr  (we_cmd && bus_wdata_i[C_CLRER]),
    .status_o (status_w)
  );

  assign rx_reset_o   = pulses[P_RSTRX];
  assign tx_reset_o   = pulses[P_RSTTX];
  assign rx_enable_o  = pulses[P_RXON];
  assign rx_disable_o = pulses[P_RXOFF];
  assign tx_enable_o  = pulses[P_TXON];
  assign tx_disable_o = pulses[P_TXOFF];
  assign err_clear_o  = pulses[P_CLRER];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o       <= 1'b0;
      bus_rdata_o <= '0;
    end else begin
      irq_o <= |(status_w & mask_q);
      if (bus_rd_i) begin
        case (bus_addr_i)
          ADDR_W'(A_MASK): bus_rdata_o <= {{PAD_W{1'b0}}, mask_q};
          ADDR_W'(A_STAT): bus_rdata_o <= {{PAD_W{1'b0}}, status_w};
          default:         bus_rdata_o <= '0;
        endcase
      end
    end
  end

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_o);
  p_wo_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i <= ADDR_W'(A_MCLR)) |=> (bus_rdata_o == '0));
endmodule

// File: tb/uart_irq_ctl_test.sv
module uart_irq_ctl_test;
  localparam int DW = 32;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr = 0, rd = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rx_rdy = 0, tx_rdy = 0, tx_empty = 0, rx_end = 0, tx_end = 0, tx_bufe = 0, rx_buff = 0;
  logic ovr = 0, frm = 0, par = 0;
  logic rx_reset, tx_reset, rx_en, rx_dis, tx_en, tx_dis, err_clr, irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uart_irq_ctl #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_rdy_i(rx_rdy), .tx_rdy_i(tx_rdy), .tx_empty_i(tx_empty), .rx_end_i(rx_end),
    .tx_end_i(tx_end), .tx_bufe_i(tx_bufe), .rx_buff_i(rx_buff),
    .ovr_evt_i(ovr), .frm_evt_i(frm), .par_evt_i(par),
    .rx_reset_o(rx_reset), .tx_reset_o(tx_reset), .rx_enable_o(rx_en),
    .rx_disable_o(rx_dis), .tx_enable_o(tx_en), .tx_disable_o(tx_dis),
    .err_clear_o(err_clr), .irq_o(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  function automatic logic [6:0] pulses();
    return {err_clr, tx_dis, tx_en, rx_dis, rx_en, tx_reset, rx_reset};
  endfunction

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R4 mask after reset", {31'b0, irq}, 0);
    bus_read(3, d); check("R4 mask reset value", d, 0);
    bus_read(4, d); check("R1 status idle", d, 0);
    check("R7 no pulses after reset", {25'b0, pulses()}, 0);
  endtask

  task automatic t_layout();
    logic [DW-1:0] d;
    {rx_rdy, tx_rdy, tx_empty, rx_end, tx_end, tx_bufe, rx_buff} = '1;
    bus_read(4, d); check("R1 all level inputs", d, 32'h1A1B);
    {rx_rdy, tx_rdy, tx_empty, rx_end, tx_end, tx_bufe, rx_buff} = '0;
    tx_empty = 1;
    bus_read(4, d); check("R1 tx empty alone at bit 9", d, 32'h200);
    tx_empty = 0;
  endtask

  task automatic t_mask();
    logic [DW-1:0] d;
    bus_write(1, 32'h3);
    bus_read(3, d); check("R2 set bits 0,1", d, 32'h3);
    bus_write(1, 32'h0);
    bus_read(3, d); check("R2 zero write keeps mask", d, 32'h3);
    bus_write(1, 32'hFFFF_FFFF);
    bus_read(3, d); check("R2 only defined bits settable", d, 32'h1AFB);
    bus_write(2, 32'h1);
    bus_read(3, d); check("R3 clear bit 0", d, 32'h1AFA);
    bus_write(2, 32'h0);
    bus_read(3, d); check("R3 zero write keeps mask", d, 32'h1AFA);
    bus_write(3, 32'h0);
    bus_read(3, d); check("R4 write to mask address ignored", d, 32'h1AFA);
    bus_write(2, 32'hFFFF_FFFF);
    bus_read(3, d); check("R3 clear all", d, 32'h0);
  endtask

  task automatic t_sticky();
    logic [DW-1:0] d;
    frm = 1; @(negedge clk); frm = 0;
    repeat (3) @(negedge clk);
    bus_read(4, d); check("R5 framing flag held", d, 32'h40);
    bus_write(0, 32'h0FC);
    bus_read(4, d); check("R5 other commands keep flag", d, 32'h40);
    bus_write(0, 32'h100);
    bus_read(4, d); check("R6 reset status clears", d, 32'h0);
  endtask

  task automatic t_race();
    logic [DW-1:0] d;
    par = 1; @(negedge clk); par = 0;
    addr = 0; wdata = 32'h100; wr = 1; ovr = 1;
    @(negedge clk);
    wr = 0; wdata = '0; ovr = 0;
    bus_read(4, d); check("R6 event beats clear in same cycle", d, 32'h20);
    bus_write(0, 32'h100);
    bus_read(4, d); check("R6 clear after race", d, 32'h0);
  endtask

  task automatic t_cmd();
    bus_write(0, 32'h1FC);
    check("R8 disable wins, all others pulse", {25'b0, pulses()}, 32'h6B);
    @(negedge clk);
    check("R7 pulses last one cycle", {25'b0, pulses()}, 0);
    bus_write(0, 32'h050);
    check("R7 enables alone", {25'b0, pulses()}, 32'h14);
    bus_write(0, 32'h00C);
    check("R7 resets only", {25'b0, pulses()}, 32'h03);
    bus_write(0, 32'h0);
    check("R7 zero command no pulse", {25'b0, pulses()}, 0);
  endtask

  task automatic t_irq();
    rx_rdy = 1;
    repeat (2) @(negedge clk);
    check("R9 unmasked status no irq", {31'b0, irq}, 0);
    bus_write(1, 32'h1);
    check("R9 irq lags mask by a cycle", {31'b0, irq}, 0);
    @(negedge clk);
    check("R9 masked status raises irq", {31'b0, irq}, 1);
    rx_rdy = 0;
    repeat (2) @(negedge clk);
    check("R9 status drop lowers irq", {31'b0, irq}, 0);
    bus_write(1, 32'h20);
    ovr = 1; @(negedge clk); ovr = 0;
    @(negedge clk);
    check("R9 sticky error raises irq", {31'b0, irq}, 1);
    bus_write(0, 32'h100);
    @(negedge clk);
    check("R9 cleared error drops irq", {31'b0, irq}, 0);
    bus_write(2, 32'hFFFF_FFFF);
  endtask

  task automatic t_wo_read();
    logic [DW-1:0] d;
    bus_write(1, 32'h1AFB);
    bus_read(0, d); check("R10 command reads zero", d, 0);
    bus_read(1, d); check("R10 mask-set reads zero", d, 0);
    bus_read(2, d); check("R10 mask-clear reads zero", d, 0);
    bus_read(3, d); check("R10 mask readback", d, 32'h1AFB);
    bus_write(2, 32'h1AFB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_layout();
    t_mask();
    t_sticky();
    t_race();
    t_cmd();
    t_irq();
    t_wo_read();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule